// File: doc/BRIEF.md
# Frame Word Alignment Controller

This block finds the word boundary of a deserialized source-synchronous ADC link. Its input is the parallel word recovered from the frame lane, which is captured like any data lane, so it carries a fixed training pattern. The block compares that word with the pattern. When they differ, it pulses a slip command. That command goes to the frame-lane deserializer and to every data-lane deserializer in the same cycle, so all lanes move their boundary together. Once the frame word lines up, the data words line up with it.

The controller runs in the divided parallel clock domain: 14-bit samples captured on both edges give one word per seven bit-clock periods. After each slip it waits for the deserializer output to settle. It declares lock only after a run of matches. It keeps comparing while locked, and after a run of mismatches it drops lock and starts slipping again by itself. If more slips than the word has bits go by without a lock, it raises an error flag. It keeps searching while that flag is set.

Top module: `frame_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, `aligned`, `align_err`, `frame_slip` and every `data_slip` bit are cleared after that edge, and the controller restarts in the searching state.
- R2: A word that is compared during search and differs from `PATTERN` (default 14'h3F80: seven ones in the upper bits, then seven zeros) produces a slip pulse exactly one cycle wide on `frame_slip` and on all `DATA_LANES` bits of `data_slip`, in the cycle after that word.
- R3: The `SETTLE_CYC` words (default 3) that follow a slip pulse are not compared, so two slip pulses are always at least `SETTLE_CYC`+1 cycles apart.
- R4: `aligned` rises only after `LOCK_MATCHES` (default 4) consecutive compared words equal `PATTERN`, in the cycle after the last of them. A mismatch before then causes a slip and restarts the count.
- R5: While `aligned` is high, no slip is issued. Fewer than `LOSS_MISSES` (default 4) consecutive mismatches leave `aligned` high.
- R6: `LOSS_MISSES` consecutive mismatches while locked clear `aligned` in the cycle after the last of them. The next mismatching word then causes a slip, and the block realigns without outside help.
- R7: `align_err` is set together with a slip pulse when `WORD_W` slips (default 14) have already been issued since the last reset or lock. It stays clear through `WORD_W` slips and is cleared when lock is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (divided) word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_word | input | WORD_W | Parallel word from the frame-lane deserializer |
| frame_slip | output | 1 | Slip pulse to the frame-lane deserializer |
| data_slip | output | DATA_LANES | Slip pulse to each data-lane deserializer, identical to `frame_slip` |
| aligned | output | 1 | Frame boundary is locked |
| align_err | output | 1 | No lock was found within more slips than the word width |

## Verification
The assertions assume that `frame_word` is a clean rotation of the training pattern whenever no fault is being injected. They also assume that a slip takes effect by the next compared word, because a deserializer that applied a slip later than the settle window would make the controller chase its own slips. The bench deserializer model moves its boundary by one bit at the falling edge after a slip is seen, well inside the window. Mismatches are injected only as whole inverted words, as a held all-zero word, or as a sudden boundary jump. The slip ports are sampled on every cycle so that pulse width, spacing and lane agreement are checked the whole time.

// File: rtl/frame_align_pkg.sv
// Shared types for the frame word alignment controller.
package frame_align_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,   // comparing words, slip on mismatch
        ST_SETTLE = 2'd1,   // waiting for deserializer output after a slip
        ST_LOCKED = 2'd2    // boundary found, watching for loss
    } align_state_t;
endpackage

// File: rtl/frame_match.sv
// Pattern comparator: flags when the frame-lane word equals the training
// pattern. Assumes the word is stable from the deserializer each cycle.
module frame_match #(
    parameter int                WORD_W  = 14,
    parameter logic [WORD_W-1:0] PATTERN = 14'h3F80
) (
    input  logic [WORD_W-1:0] word,
    output logic              match
);
    // Full-width equality against the fixed pattern.
    always_comb match = (word == PATTERN);
endmodule

// File: rtl/run_counter.sv
// Consecutive-event counter: counts cycles with hit high, clears on any
// cycle with hit low, and reports the cycle that completes LIMIT hits.
// Assumes LIMIT >= 1; the count wraps to zero on completion.
module run_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Completion is seen combinationally in the cycle of the last hit.
    always_comb reached = hit && (cnt == LAST);

    // Track the length of the current unbroken run of hits.
    always_ff @(posedge clk) begin
        if (!rst_n || !hit) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/settle_timer.sv
// Settle window timer: loading starts a window of CYC cycles; done is
// high once the window has run out. Assumes CYC >= 1.
module settle_timer #(
    parameter int CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Window has expired when the count is back at zero.
    always_comb done = (cnt == '0);

    // Load on a slip, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (load) cnt <= CW'(CYC - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/frame_aligner.sv
// Frame word alignment controller. Compares the frame-lane word with a
// training pattern. On a mismatch during search it pulses one shared slip
// to the frame lane and all data lanes, then ignores SETTLE_CYC words.
// Lock needs LOCK_MATCHES matches in a row; loss needs LOSS_MISSES
// mismatches in a row. An error flag is raised when more than WORD_W slips
// pass without lock. Assumes a slip moves the deserializer boundary by one
// bit within the settle window. Synchronous active-low reset.
module frame_aligner #(
    parameter int                WORD_W       = 14,
    parameter logic [WORD_W-1:0] PATTERN      = 14'h3F80,
    parameter int                DATA_LANES   = 4,
    parameter int                LOCK_MATCHES = 4,
    parameter int                LOSS_MISSES  = 4,
    parameter int                SETTLE_CYC   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     frame_word,
    output logic                  frame_slip,
    output logic [DATA_LANES-1:0] data_slip,
    output logic                  aligned,
    output logic                  align_err
);
    import frame_align_pkg::*;

    localparam int SC_W = $clog2(WORD_W + 2);
    localparam logic [SC_W-1:0] SLIP_BUDGET = SC_W'(WORD_W);

    align_state_t    state;
    logic            match, search_hit, search_miss, locked_miss;
    logic            lock_now, loss_now, settle_done;
    logic [SC_W-1:0] slip_cnt;

    frame_match #(.WORD_W(WORD_W), .PATTERN(PATTERN)) u_match (
        .word  (frame_word),
        .match (match)
    );

    // Qualify the comparison by the state it happens in.
    always_comb begin
        search_hit  = (state == ST_SEARCH) && match;
        search_miss = (state == ST_SEARCH) && !match;
        locked_miss = (state == ST_LOCKED) && !match;
    end

    run_counter #(.LIMIT(LOCK_MATCHES)) u_hit_run (
        .clk (clk), .rst_n (rst_n), .hit (search_hit), .reached (lock_now)
    );

    run_counter #(.LIMIT(LOSS_MISSES)) u_miss_run (
        .clk (clk), .rst_n (rst_n), .hit (locked_miss), .reached (loss_now)
    );

    settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk (clk), .rst_n (rst_n), .load (search_miss), .done (settle_done)
    );

    // Sequence search, settle and lock.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEARCH;
        else begin
            case (state)
                ST_SEARCH: if (lock_now) state <= ST_LOCKED;
                           else if (search_miss) state <= ST_SETTLE;
                ST_SETTLE: if (settle_done) state <= ST_SEARCH;
                ST_LOCKED: if (loss_now) state <= ST_SEARCH;
                default:   state <= ST_SEARCH;
            endcase
        end
    end

    // Lock status, set on a completed match run and cleared on a miss run.
    always_ff @(posedge clk) begin
        if (!rst_n || loss_now) aligned <= 1'b0;
        else if (lock_now) aligned <= 1'b1;
    end

    // Count slips since reset or lock, saturating one past the budget.
    always_ff @(posedge clk) begin
        if (!rst_n || lock_now || loss_now) slip_cnt <= '0;
        else if (search_miss && slip_cnt <= SLIP_BUDGET) slip_cnt <= slip_cnt + 1'b1;
    end

    // Error flag: a slip issued with the budget already spent.
    always_ff @(posedge clk) begin
        if (!rst_n || lock_now) align_err <= 1'b0;
        else if (search_miss && slip_cnt >= SLIP_BUDGET) align_err <= 1'b1;
    end

    // Frame-lane slip register.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_slip <= 1'b0;
        else frame_slip <= search_miss;
    end

    // One slip register per data lane, to keep fanout local to each lane.
    for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) data_slip[g] <= 1'b0;
            else data_slip[g] <= search_miss;
        end
    end
endmodule

// File: rtl/frame_aligner_checker.sv
// Property checker for frame_aligner, attached by bind. Assumes the same
// parameter values as the bound instance.
module frame_aligner_checker #(
    parameter int                WORD_W     = 14,
    parameter logic [WORD_W-1:0] PATTERN    = 14'h3F80,
    parameter int                DATA_LANES = 4,
    parameter int                SETTLE_CYC = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [WORD_W-1:0]     frame_word,
    input logic                  frame_slip,
    input logic [DATA_LANES-1:0] data_slip,
    input logic                  aligned,
    input logic                  align_err
);
    localparam int GW = $clog2(SETTLE_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(SETTLE_CYC);

    logic [GW-1:0] gap;

    // Cycles seen since the last slip pulse, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) gap <= GAP_MAX;
        else if (frame_slip) gap <= '0;
        else if (gap != GAP_MAX) gap <= gap + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!aligned && !align_err && !frame_slip && data_slip == '0)); // R1
    AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frame_slip |=> !frame_slip); // R2
    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) data_slip == {DATA_LANES{frame_slip}}); // R2
    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n) frame_slip |-> gap >= GAP_MAX); // R3
    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(aligned) |-> $past(frame_word == PATTERN)); // R4
    AST_QUIET_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) aligned |-> !frame_slip); // R5
    AST_LOSS_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n) $fell(aligned) |-> $past(frame_word != PATTERN)); // R6
    AST_ERR_CLEAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) aligned |-> !align_err); // R7
endmodule

bind frame_aligner frame_aligner_checker #(
    .WORD_W(WORD_W), .PATTERN(PATTERN), .DATA_LANES(DATA_LANES), .SETTLE_CYC(SETTLE_CYC)
) u_chk (.*);

// File: tb/frame_aligner_bench.sv
// Directed bench: models frame and data deserializers whose boundary moves
// one bit per slip, and checks the controller scenario by scenario.
module frame_aligner_bench;
    localparam int W = 14;
    localparam int LANES = 4;
    localparam int SETTLE = 3;
    localparam int LOCKN = 4;
    localparam int LOSSN = 4;
    localparam logic [W-1:0] PAT = 14'h3F80;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     frame_word;
    logic             frame_slip;
    logic [LANES-1:0] data_slip;
    logic             aligned, align_err;

    int checks = 0, errors = 0;
    int off = 0, skew = 0;
    int dl_off [LANES] = '{default: 0};
    logic corrupt = 1'b0, force_zero = 1'b0;

    frame_aligner #(
        .WORD_W(W), .PATTERN(PAT), .DATA_LANES(LANES),
        .LOCK_MATCHES(LOCKN), .LOSS_MISSES(LOSSN), .SETTLE_CYC(SETTLE)
    ) u_frame_aligner (.*);

    always #4 clk = ~clk;

    function automatic logic [W-1:0] rotl(int s);
        logic [2*W-1:0] dbl;
        dbl = {PAT, PAT} >> (W - s);
        return dbl[W-1:0];
    endfunction

    // Deserializer model: word is the pattern rotated by the boundary offset.
    always_comb begin
        if (force_zero) frame_word = '0;
        else if (corrupt) frame_word = ~rotl((off + skew) % W);
        else frame_word = rotl((off + skew) % W);
    end

    // Boundaries move one bit at the falling edge after a slip pulse.
    always @(negedge clk) begin
        if (frame_slip) off <= (off + 1) % W;
        for (int i = 0; i < LANES; i++)
            if (data_slip[i]) dl_off[i] <= (dl_off[i] + 1) % W;
    end

    task automatic chk(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(int start);
        rst_n = 1'b0; corrupt = 1'b0; force_zero = 1'b0;
        repeat (3) @(negedge clk);
        skew = (start + W - off) % W;
        chk("R1 aligned in reset", aligned == 1'b0, aligned, 0);
        chk("R1 err in reset", align_err == 1'b0, align_err, 0);
        chk("R1 slips in reset", {frame_slip, data_slip} == '0, {frame_slip, data_slip}, 0);
        rst_n = 1'b1;
    endtask

    // Wait for lock while watching every slip; exp_slips < 0 skips count check.
    task automatic acquire(string tag, int exp_slips);
        int n = 0, last = 0, cyc = 0;
        bit pulse_ok = 1, gap_ok = 1, lanes_ok = 1, prev = 0, same = 1;
        while (!aligned && cyc < 400) begin
            @(negedge clk); cyc++;
            if (frame_slip) begin
                if (prev) pulse_ok = 0;
                if (n > 0 && cyc - last < SETTLE + 1) gap_ok = 0;
                if (data_slip != '1) lanes_ok = 0;
                n++; last = cyc;
            end else if (data_slip != '0) lanes_ok = 0;
            prev = frame_slip;
        end
        $display("%s: %0d slips, lock after %0d cycles", tag, n, cyc);
        chk("R4 lock reached", aligned == 1'b1, aligned, 1);
        if (exp_slips >= 0) chk("R2 slip count", n == exp_slips, n, exp_slips);
        chk("R2 single-cycle pulses", pulse_ok, pulse_ok, 1);
        chk("R3 slip spacing", gap_ok, gap_ok, 1);
        chk("R2 lanes slip together", lanes_ok, lanes_ok, 1);
        if (n > 0) chk("R4 lock latency after last slip", cyc - last == SETTLE + LOCKN, cyc - last, SETTLE + LOCKN);
        for (int i = 0; i < LANES; i++) if (dl_off[i] != off) same = 0;
        chk("R2 data lanes follow frame", same, same, 1);
    endtask

    task automatic t_glitch();
        bit kept = 1;
        corrupt = 1'b1;
        repeat (LOSSN - 1) @(negedge clk);
        corrupt = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (!aligned || frame_slip) kept = 0;
        end
        chk("R5 short miss run keeps lock, no slip", kept, kept, 1);
    endtask

    task automatic t_loss();
        bit early = 0;
        skew = (skew + 3) % W;
        for (int i = 1; i <= LOSSN; i++) begin
            @(negedge clk);
            if (i < LOSSN && (!aligned || frame_slip)) early = 1;
        end
        chk("R6 lock held until miss run completes", !early, early, 0);
        chk("R6 lock dropped after miss run", aligned == 1'b0, aligned, 0);
        acquire("R6 realign", W - 3);
    endtask

    task automatic t_restart();
        do_reset(0);
        @(negedge clk); @(negedge clk);
        chk("R4 no lock after two matches", aligned == 1'b0, aligned, 0);
        corrupt = 1'b1;
        @(negedge clk);
        corrupt = 1'b0;
        chk("R4 mismatch in run slips", frame_slip == 1'b1, frame_slip, 1);
        chk("R4 mismatch in run blocks lock", aligned == 1'b0, aligned, 0);
        acquire("R4 restart", W - 1);
        chk("R7 no error at exactly WORD_W slips", align_err == 1'b0, align_err, 0);
    endtask

    task automatic t_error();
        int n = 0, cyc = 0;
        bit early = 0, late = 0;
        do_reset(4);
        force_zero = 1'b1;
        while (n < W + 1 && cyc < 200) begin
            @(negedge clk); cyc++;
            if (frame_slip) begin
                n++;
                if (n == W + 1 && !align_err) late = 1;
            end
            if (n <= W && align_err) early = 1;
        end
        chk("R7 err clear through WORD_W slips", !early, early, 0);
        chk("R7 err set on slip past budget", !late && n == W + 1, n, W + 1);
        force_zero = 1'b0;
        acquire("R7 recover", -1);
        chk("R7 err cleared at lock", align_err == 1'b0, align_err, 0);
        force_zero = 1'b1;
        repeat (80) @(negedge clk);
        chk("R7 err set again", align_err == 1'b1, align_err, 1);
        do_reset(0);
        chk("R1 err cleared by reset", align_err == 1'b0, align_err, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(5);
        acquire("R2 first acquire", W - 5);
        t_glitch();
        t_loss();
        t_restart();
        t_error();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule